// File: doc/BRIEF.md
# LED Driver Fault Supervisor

This block is the digital sequencer of an LED driver controller. It watches comparator results that arrive already digitized and carry whatever hysteresis they need: supply undervoltage, over-temperature, switch current limit, output overvoltage, LED overcurrent, output undervoltage, soft-start voltage near zero and compensation voltage below its floor. From these it decides when the power switch may run, when the soft-start and compensation capacitors are discharged or charged, and when the active-low open-drain fault line is pulled down.

Faults are handled in two classes. Protective faults stop switching, discharge soft start and pull the fault line low. A current-limit trip then waits a fixed time. An overvoltage trip waits until its flag drops. After either wait, a fresh soft start begins. Report-only faults pulse the fault line low for a fixed hold time while the converter keeps switching. With hiccup enabled, the same faults instead stop the converter for the hold time and then restart it, as if the fault line were wired back to soft start. Supply undervoltage and over-temperature override everything else and force a quiet standby.

All times are whole clock cycles and are set by parameters: current-limit wait, fault hold and soft-start ramp (the window in which output undervoltage is ignored). Every output is decoded from registered state, so each output responds at the clock edge that samples the input. The one exception is switching enable, which the compensation floor flag also gates directly.

Top module: `led_fault_supervisor`

## Requirements
- R1: While reset is held and in the first cycle after it, the outputs are sw_en=0, ss_dis=1, ss_chg=0 and flt_n=1.
- R2: A high uv_flag or hot_flag forces standby from the next cycle, with sw_en=0, ss_dis=1, ss_chg=0 and flt_n=1. A cycle later the block moves to the discharge phase once both flags are low.
- R3: In the discharge phase, ss_dis=1 and ss_chg=0 until a cycle samples ss_low_flag=1 with ss_pull_req=0. From the next cycle ss_dis=0, ss_chg=1 and sw_en=1 (unless the compensation floor flag is high).
- R4: While ss_pull_req is high, the block is held in the discharge phase (ss_dis=1, ss_chg=0), or is returned to it from the following cycle if it was charging.
- R5: A current-limit flag sampled while charging gives, from the next cycle, sw_en=0, ss_dis=1 and flt_n=0 for exactly ILIM_WAIT_CYC cycles. After that flt_n=1 and the discharge phase begins.
- R6: An overvoltage flag sampled while charging or discharging gives sw_en=0, ss_dis=1 and flt_n=0 from the next cycle. This holds until the cycle after the flag is sampled low, when the discharge phase begins.
- R7: With hiccup off, an LED overcurrent flag sampled while charging drives flt_n=0 for exactly FLT_HOLD_CYC cycles while sw_en and ss_chg stay 1. A sustained flag repeats the pulse with flt_n=1 for a single cycle between pulses.
- R8: An output undervoltage flag has no effect during the first RAMP_CYC cycles of charging, or while pwm_on is 0. Otherwise it acts as a report-only fault, like R7.
- R9: With hiccup_en=1, a report-only fault sampled while charging gives sw_en=0, ss_dis=1 and flt_n=0 for exactly FLT_HOLD_CYC cycles, then the discharge phase.
- R10: comp_low_flag=1 forces sw_en=0 in the same cycle and leaves flt_n and the soft-start outputs unchanged.
- R11: When faults coincide, standby causes win over current limit, current limit over overvoltage, overvoltage over the pull-down request, and the pull-down request over report-only faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uv_flag | input | 1 | Bias supply below its undervoltage threshold |
| hot_flag | input | 1 | Die temperature in the shutdown region |
| ilim_flag | input | 1 | Switch current above the cycle limit |
| ovp_flag | input | 1 | Output above the overvoltage threshold |
| led_oc_flag | input | 1 | LED current above the overcurrent level |
| out_uv_flag | input | 1 | Output below the undervoltage level |
| ss_low_flag | input | 1 | Soft-start voltage below its floor |
| comp_low_flag | input | 1 | Compensation voltage below its floor |
| pwm_on | input | 1 | Internal dimming signal is high |
| ss_pull_req | input | 1 | External request to hold soft start discharged |
| hiccup_en | input | 1 | Report-only faults restart the converter |
| sw_en | output | 1 | Power switch and dimming switch allowed to run |
| ss_dis | output | 1 | Discharge soft-start and compensation capacitors |
| ss_chg | output | 1 | Soft-start charge current on |
| flt_n | output | 1 | Fault line, 0 = pulled low |

## Verification
Directed sequences bring the block through each phase: standby, discharge, ramp, steady run, current-limit wait, overvoltage hold and hiccup. Pulse lengths are counted at the fault line, which separates the fixed current-limit wait from the fault hold time and from the flag-controlled overvoltage hold. An output undervoltage flag is applied during the ramp, with dimming low, and then in steady run. This separates masking from a missing detector. Coincident flags check the priority order. A long stretch of random flag activity with a fixed seed then compares every output, every cycle, against a cycle model written from the requirements.

// File: rtl/led_sup_pkg.sv
// Shared types for the LED driver fault supervisor.
// Assumes: state codes are internal only; no other block decodes them.
package led_sup_pkg;

    typedef enum logic [2:0] {
        ST_STBY  = 3'd0,   // standby: supply or thermal cause present
        ST_DISCH = 3'd1,   // soft start held discharged
        ST_RAMP  = 3'd2,   // charging, output undervoltage masked
        ST_RUN   = 3'd3,   // steady operation
        ST_ILIM  = 3'd4,   // current-limit wait
        ST_OVP   = 3'd5,   // overvoltage hold
        ST_HIC   = 3'd6    // hiccup off-time
    } sup_state_t;

    // True for states in which the converter switches and soft start charges.
    function automatic logic is_charging(sup_state_t s);
        return (s == ST_RAMP) || (s == ST_RUN);
    endfunction

    // True for states that pull the fault line low on their own.
    function automatic logic is_fault_state(sup_state_t s);
        return (s == ST_ILIM) || (s == ST_OVP) || (s == ST_HIC);
    endfunction

endpackage

// File: rtl/led_sup_timer.sv
// Load-and-count-down cycle timer.
// Loading with N makes busy high for exactly N cycles, starting the cycle
// after the load. last marks the final busy cycle. clr aborts a running count.
// Assumes: N >= 1 and N fits in TW bits.
module led_sup_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clr,
    input  logic [TW-1:0] len,
    output logic          busy,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    // Count register: clear, load or step down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (clr) begin
            busy  <= 1'b0;
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= len;
        end else if (busy) begin
            if (cnt_q == TW'(1)) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - TW'(1);
            end
        end
    end

    // Final-cycle marker.
    always_comb begin
        last = busy && (cnt_q == TW'(1));
    end

endmodule

// File: rtl/led_sup_report.sv
// Report-only fault pulse generator.
// While enabled, a request starts a pulse of exactly HOLD_CYC cycles. No new
// pulse starts until the cycle after the current one ends, so a held request
// gives pulses separated by one idle cycle. Dropping enable ends the pulse at
// once.
// Assumes: HOLD_CYC >= 1.
module led_sup_report #(
    parameter int HOLD_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req,
    output logic active
);

    localparam int TW = $clog2(HOLD_CYC + 1);

    logic [TW-1:0] cnt_q;

    // Pulse state and remaining-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cnt_q  <= '0;
        end else if (!enable) begin
            active <= 1'b0;
        end else if (active) begin
            if (cnt_q == TW'(1)) begin
                active <= 1'b0;
            end else begin
                cnt_q <= cnt_q - TW'(1);
            end
        end else if (req) begin
            active <= 1'b1;
            cnt_q  <= TW'(HOLD_CYC);
        end
    end

endmodule

// File: rtl/led_sup_fsm.sv
// Sequencing state machine of the fault supervisor.
// Chooses the next phase from the flags by fixed priority, and runs one
// shared timer for the ramp, current-limit and hiccup phases.
// Assumes: all flags are synchronous to clk, and each timing parameter >= 1.
module led_sup_fsm
    import led_sup_pkg::*;
#(
    parameter int ILIM_WAIT_CYC = 4375,
    parameter int FLT_HOLD_CYC  = 4500000,
    parameter int RAMP_CYC      = 125000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby_req,
    input  logic       ilim_flag,
    input  logic       ovp_flag,
    input  logic       ss_low_flag,
    input  logic       ss_pull_req,
    input  logic       hiccup_en,
    input  logic       rep_req,
    output sup_state_t state_q,
    output logic       charge_next
);

    localparam int MAX_A = (ILIM_WAIT_CYC > FLT_HOLD_CYC) ? ILIM_WAIT_CYC : FLT_HOLD_CYC;
    localparam int MAX_C = (MAX_A > RAMP_CYC) ? MAX_A : RAMP_CYC;
    localparam int TW    = $clog2(MAX_C + 1);

    sup_state_t    state_d;
    logic          tmr_start;
    logic          tmr_clr;
    logic [TW-1:0] tmr_len;
    logic          tmr_busy;
    logic          tmr_last;
    logic          tmr_over;
    logic          timed_next;

    // A timed phase ends on its last counted cycle, or if the count was lost.
    always_comb begin
        tmr_over = tmr_last || !tmr_busy;
    end

    // Next-phase selection in priority order.
    always_comb begin
        state_d = state_q;
        if (standby_req) begin
            state_d = ST_STBY;
        end else begin
            unique case (state_q)
                ST_STBY:  state_d = ST_DISCH;
                ST_DISCH: begin
                    if (ovp_flag) begin
                        state_d = ST_OVP;
                    end else if (ss_low_flag && !ss_pull_req) begin
                        state_d = ST_RAMP;
                    end
                end
                ST_RAMP, ST_RUN: begin
                    if (ilim_flag) begin
                        state_d = ST_ILIM;
                    end else if (ovp_flag) begin
                        state_d = ST_OVP;
                    end else if (ss_pull_req) begin
                        state_d = ST_DISCH;
                    end else if (hiccup_en && rep_req) begin
                        state_d = ST_HIC;
                    end else if ((state_q == ST_RAMP) && tmr_over) begin
                        state_d = ST_RUN;
                    end
                end
                ST_ILIM, ST_HIC: begin
                    if (tmr_over) begin
                        state_d = ST_DISCH;
                    end
                end
                ST_OVP: begin
                    if (!ovp_flag) begin
                        state_d = ST_DISCH;
                    end
                end
                default:  state_d = ST_STBY;
            endcase
        end
    end

    // Timer load on entry to a timed phase; length picked by that phase.
    always_comb begin
        timed_next = (state_d == ST_RAMP) || (state_d == ST_ILIM) || (state_d == ST_HIC);
        tmr_start  = timed_next && (state_d != state_q);
        tmr_clr    = !timed_next;
        charge_next = is_charging(state_d);
        unique case (state_d)
            ST_ILIM: tmr_len = TW'(ILIM_WAIT_CYC);
            ST_HIC:  tmr_len = TW'(FLT_HOLD_CYC);
            default: tmr_len = TW'(RAMP_CYC);
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STBY;
        end else begin
            state_q <= state_d;
        end
    end

    led_sup_timer #(
        .TW (TW)
    ) i_phase_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .clr   (tmr_clr),
        .len   (tmr_len),
        .busy  (tmr_busy),
        .last  (tmr_last)
    );

endmodule

// File: rtl/led_fault_supervisor.sv
// Top of the LED driver fault supervisor.
// Combines the sequencing machine with the report-only pulse generator and
// decodes the four control outputs.
// Assumes: inputs are clean synchronous flags; flt_n = 0 means the open-drain
// line is pulled low.
module led_fault_supervisor
    import led_sup_pkg::*;
#(
    parameter int ILIM_WAIT_CYC = 4375,
    parameter int FLT_HOLD_CYC  = 4500000,
    parameter int RAMP_CYC      = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_flag,
    input  logic hot_flag,
    input  logic ilim_flag,
    input  logic ovp_flag,
    input  logic led_oc_flag,
    input  logic out_uv_flag,
    input  logic ss_low_flag,
    input  logic comp_low_flag,
    input  logic pwm_on,
    input  logic ss_pull_req,
    input  logic hiccup_en,
    output logic sw_en,
    output logic ss_dis,
    output logic ss_chg,
    output logic flt_n
);

    sup_state_t state_q;
    logic       charge_next;
    logic       rep_req;
    logic       rep_active;

    // Report-only fault request; output undervoltage masked in ramp and dim-off.
    always_comb begin
        rep_req = led_oc_flag || (out_uv_flag && pwm_on && (state_q == ST_RUN));
    end

    led_sup_fsm #(
        .ILIM_WAIT_CYC (ILIM_WAIT_CYC),
        .FLT_HOLD_CYC  (FLT_HOLD_CYC),
        .RAMP_CYC      (RAMP_CYC)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .standby_req (uv_flag || hot_flag),
        .ilim_flag   (ilim_flag),
        .ovp_flag    (ovp_flag),
        .ss_low_flag (ss_low_flag),
        .ss_pull_req (ss_pull_req),
        .hiccup_en   (hiccup_en),
        .rep_req     (rep_req),
        .state_q     (state_q),
        .charge_next (charge_next)
    );

    led_sup_report #(
        .HOLD_CYC (FLT_HOLD_CYC)
    ) i_report (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (charge_next && !hiccup_en),
        .req    (rep_req),
        .active (rep_active)
    );

    // Output decode from registered phase and pulse state.
    always_comb begin
        ss_chg = is_charging(state_q);
        ss_dis = !is_charging(state_q);
        sw_en  = is_charging(state_q) && !comp_low_flag;
        flt_n  = !(is_fault_state(state_q) || rep_active);
    end

endmodule

// File: rtl/led_sup_checker.sv
// Property checker for the LED driver fault supervisor, bound to the top.
// Observes ports only.
module led_sup_checker (
    input logic clk,
    input logic rst_n,
    input logic uv_flag,
    input logic hot_flag,
    input logic ilim_flag,
    input logic ovp_flag,
    input logic ss_low_flag,
    input logic ss_pull_req,
    input logic sw_en,
    input logic ss_dis,
    input logic ss_chg,
    input logic flt_n
);

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (uv_flag || hot_flag) |=> (!sw_en && ss_dis && !ss_chg && flt_n)); // R2

    AST_CHARGE_AFTER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_chg) |-> $past(ss_low_flag && !ss_pull_req)); // R3

    AST_PULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ss_pull_req |=> (ss_dis && !ss_chg)); // R4

    AST_ILIM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_chg && ilim_flag && !uv_flag && !hot_flag) |=> (!sw_en && ss_dis && !flt_n)); // R5

    AST_OVP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_chg && ovp_flag && !ilim_flag && !uv_flag && !hot_flag)
        |=> (!sw_en && ss_dis && !flt_n)); // R6

    AST_OVP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_dis && ovp_flag) |=> ss_dis); // R6

endmodule

bind led_fault_supervisor led_sup_checker i_sup_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .uv_flag     (uv_flag),
    .hot_flag    (hot_flag),
    .ilim_flag   (ilim_flag),
    .ovp_flag    (ovp_flag),
    .ss_low_flag (ss_low_flag),
    .ss_pull_req (ss_pull_req),
    .sw_en       (sw_en),
    .ss_dis      (ss_dis),
    .ss_chg      (ss_chg),
    .flt_n       (flt_n)
);

// File: tb/test_led_fault_supervisor.sv
// Bench for the LED driver fault supervisor: directed phases, then random
// flag activity, with all outputs compared every cycle to a model written
// from the requirements.
module test_led_fault_supervisor;

    localparam int ILIM_N = 20;
    localparam int HOLD_N = 50;
    localparam int RAMP_N = 30;

    localparam int M_STBY = 0, M_DISCH = 1, M_RAMP = 2, M_RUN = 3,
                   M_ILIM = 4, M_OVP = 5, M_HIC = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv_flag = 0, hot_flag = 0, ilim_flag = 0, ovp_flag = 0;
    logic led_oc_flag = 0, out_uv_flag = 0, ss_low_flag = 0, comp_low_flag = 0;
    logic pwm_on = 1, ss_pull_req = 0, hiccup_en = 0;
    logic sw_en, ss_dis, ss_chg, flt_n;

    int checks = 0;
    int errors = 0;

    int m_st = M_STBY;
    int m_left = 0;
    bit m_busy = 0;
    int m_rcnt = 0;

    always #4 clk = ~clk;

    led_fault_supervisor #(
        .ILIM_WAIT_CYC (ILIM_N),
        .FLT_HOLD_CYC  (HOLD_N),
        .RAMP_CYC      (RAMP_N)
    ) i_led_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .hot_flag(hot_flag),
        .ilim_flag(ilim_flag), .ovp_flag(ovp_flag), .led_oc_flag(led_oc_flag),
        .out_uv_flag(out_uv_flag), .ss_low_flag(ss_low_flag),
        .comp_low_flag(comp_low_flag), .pwm_on(pwm_on), .ss_pull_req(ss_pull_req),
        .hiccup_en(hiccup_en), .sw_en(sw_en), .ss_dis(ss_dis), .ss_chg(ss_chg),
        .flt_n(flt_n)
    );

    // Requirement model, advanced on each rising edge.
    always @(posedge clk) begin
        int  nst;
        bit  rep;
        bit  en;
        if (!rst_n) begin
            m_st = M_STBY; m_left = 0; m_busy = 0; m_rcnt = 0;
        end else begin
            rep = led_oc_flag || (out_uv_flag && pwm_on && m_st == M_RUN);
            nst = m_st;
            if (uv_flag || hot_flag) nst = M_STBY;
            else case (m_st)
                M_STBY:  nst = M_DISCH;
                M_DISCH: if (ovp_flag) nst = M_OVP;
                         else if (ss_low_flag && !ss_pull_req) nst = M_RAMP;
                M_RAMP, M_RUN: begin
                    if (ilim_flag) nst = M_ILIM;
                    else if (ovp_flag) nst = M_OVP;
                    else if (ss_pull_req) nst = M_DISCH;
                    else if (hiccup_en && rep) nst = M_HIC;
                    else if (m_st == M_RAMP && m_left == 1) nst = M_RUN;
                end
                M_ILIM, M_HIC: if (m_left == 1) nst = M_DISCH;
                M_OVP:   if (!ovp_flag) nst = M_DISCH;
                default: nst = M_STBY;
            endcase
            if (nst != m_st) begin
                if (nst == M_RAMP) m_left = RAMP_N;
                else if (nst == M_ILIM) m_left = ILIM_N;
                else if (nst == M_HIC) m_left = HOLD_N;
            end else begin
                m_left = m_left - 1;
            end
            en = (nst == M_RAMP || nst == M_RUN) && !hiccup_en;
            if (!en) m_busy = 0;
            else if (m_busy) begin
                if (m_rcnt == 1) m_busy = 0; else m_rcnt = m_rcnt - 1;
            end else if (rep) begin
                m_busy = 1; m_rcnt = HOLD_N;
            end
            m_st = nst;
        end
    end

    task automatic check_v(string tag, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, name, act, exp);
        end
    endtask

    // Compare all outputs with the model.
    task automatic compare_all(string tag);
        bit e_chg, e_sw, e_flt;
        e_chg = (m_st == M_RAMP) || (m_st == M_RUN);
        e_sw  = e_chg && !comp_low_flag;
        e_flt = !((m_st == M_ILIM) || (m_st == M_OVP) || (m_st == M_HIC) || m_busy);
        check_v(tag, "sw_en",  int'(sw_en),  int'(e_sw));
        check_v(tag, "ss_chg", int'(ss_chg), int'(e_chg));
        check_v(tag, "ss_dis", int'(ss_dis), int'(!e_chg));
        check_v(tag, "flt_n",  int'(flt_n),  int'(e_flt));
    endtask

    function automatic string tag_of(int st);
        case (st)
            M_STBY:  return "R2";
            M_DISCH: return "R3";
            M_RAMP:  return "R8";
            M_RUN:   return "R7";
            M_ILIM:  return "R5";
            M_OVP:   return "R6";
            default: return "R9";
        endcase
    endfunction

    // One clock: let the edge pass, then compare at the falling edge.
    task automatic cyc(string tag);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic cycs(string tag, int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    function automatic logic flip(logic cur, int on_den, int off_den);
        if (cur) return ($urandom % off_den) != 0;
        return ($urandom % on_den) == 0;
    endfunction

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int lows;
        int highs;
        int swl;
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset state
        cycs("R1", 3);
        check_v("R1", "flt_n", int'(flt_n), 1);
        check_v("R1", "ss_dis", int'(ss_dis), 1);
        rst_n = 1'b1;
        cyc("R1");
        check_v("R1", "sw_en", int'(sw_en), 0);
        // R3: discharge held until floor seen
        cycs("R3", 5);
        check_v("R3", "ss_dis", int'(ss_dis), 1);
        ss_low_flag = 1; out_uv_flag = 1;
        cyc("R3");
        check_v("R3", "ss_chg", int'(ss_chg), 1);
        // R8: output undervoltage masked in ramp
        cycs("R8", 10);
        check_v("R8", "flt_n", int'(flt_n), 1);
        out_uv_flag = 0;
        cycs("R8", RAMP_N);
        // R7: single report pulse length, switching continues
        led_oc_flag = 1;
        cyc("R7");
        led_oc_flag = 0;
        lows = 1; swl = 0;
        for (int i = 0; i < HOLD_N + 5; i++) begin
            cyc("R7");
            if (!flt_n) lows++;
            if (!sw_en) swl++;
        end
        check_v("R7", "pulse_len", lows, HOLD_N);
        check_v("R7", "sw_off_cycles", swl, 0);
        // R8: masked while dimming signal low, active when high
        pwm_on = 0; out_uv_flag = 1;
        cycs("R8", 20);
        check_v("R8", "flt_n", int'(flt_n), 1);
        pwm_on = 1;
        cyc("R8");
        check_v("R8", "flt_n", int'(flt_n), 0);
        out_uv_flag = 0;
        cycs("R8", HOLD_N + 3);
        // R7: sustained fault toggles with one high cycle
        led_oc_flag = 1;
        lows = 0; highs = 0;
        for (int i = 0; i < 2 * HOLD_N + 2; i++) begin
            cyc("R7");
            if (flt_n) highs++; else lows++;
        end
        check_v("R7", "gap_cycles", highs, 2);
        check_v("R7", "low_cycles", lows, 2 * HOLD_N);
        led_oc_flag = 0;
        cycs("R7", HOLD_N + 3);
        // R10: compensation floor stops switching without fault
        comp_low_flag = 1;
        @(negedge clk);
        compare_all("R10");
        check_v("R10", "sw_en", int'(sw_en), 0);
        cycs("R10", 3);
        check_v("R10", "flt_n", int'(flt_n), 1);
        comp_low_flag = 0;
        cyc("R10");
        // R5: current-limit wait length
        ilim_flag = 1;
        cyc("R5");
        ilim_flag = 0;
        lows = 1;
        for (int i = 0; i < ILIM_N + 5; i++) begin
            cyc("R5");
            if (!flt_n) lows++;
        end
        check_v("R5", "wait_len", lows, ILIM_N);
        cycs("R5", RAMP_N + 3);
        // R6: overvoltage hold follows the flag
        ovp_flag = 1;
        cycs("R6", 40);
        check_v("R6", "flt_n", int'(flt_n), 0);
        ovp_flag = 0;
        cyc("R6");
        check_v("R6", "ss_dis", int'(ss_dis), 1);
        cycs("R6", RAMP_N + 5);
        // R4: external pull-down holds discharge
        ss_pull_req = 1;
        cycs("R4", 10);
        check_v("R4", "ss_dis", int'(ss_dis), 1);
        ss_pull_req = 0;
        cycs("R4", RAMP_N + 5);
        // R9: hiccup off-time
        hiccup_en = 1; led_oc_flag = 1;
        cyc("R9");
        led_oc_flag = 0;
        lows = 1; swl = 1;
        for (int i = 0; i < HOLD_N + 3; i++) begin
            cyc("R9");
            if (!flt_n) lows++;
            if (!sw_en) swl++;
        end
        check_v("R9", "off_len", lows, HOLD_N);
        check_v("R9", "sw_off_len", swl, HOLD_N + 1);
        hiccup_en = 0;
        cycs("R9", RAMP_N + 5);
        // R11: standby beats current limit
        uv_flag = 1; ilim_flag = 1;
        cyc("R11");
        check_v("R11", "flt_n", int'(flt_n), 1);
        uv_flag = 0; ilim_flag = 0;
        cycs("R11", RAMP_N + 5);
        // R11: current limit beats overvoltage, overvoltage follows
        ilim_flag = 1; ovp_flag = 1;
        cyc("R11");
        ilim_flag = 0;
        cycs("R11", ILIM_N + 3);
        check_v("R11", "flt_n", int'(flt_n), 0);
        ovp_flag = 0;
        cycs("R11", RAMP_N + 5);
        // R2: thermal and supply causes
        hot_flag = 1;
        cycs("R2", 5);
        hot_flag = 0;
        cycs("R2", 3);
        uv_flag = 1;
        cycs("R2", 5);
        uv_flag = 0;
        cycs("R2", RAMP_N + 5);
        // Random flag activity
        for (int i = 0; i < 20000; i++) begin
            uv_flag       = flip(uv_flag, 3000, 6);
            hot_flag      = flip(hot_flag, 4000, 6);
            ilim_flag     = flip(ilim_flag, 500, 2);
            ovp_flag      = flip(ovp_flag, 700, 20);
            led_oc_flag   = flip(led_oc_flag, 300, 30);
            out_uv_flag   = flip(out_uv_flag, 300, 30);
            ss_low_flag   = flip(ss_low_flag, 4, 20);
            comp_low_flag = flip(comp_low_flag, 200, 3);
            pwm_on        = flip(pwm_on, 10, 30);
            ss_pull_req   = flip(ss_pull_req, 1500, 8);
            hiccup_en     = flip(hiccup_en, 3000, 3000);
            cyc(tag_of(m_st));
        end
        summary();
        $finish;
    end

endmodule